// File: doc/BRIEF.md
# SAR Converter Serial Readout Model

This block is a synthesizable bus-functional model of the digital side of a successive-approximation converter with a serial output. A testbench or emulation host drives a convert strobe, an active-low select line and a serial clock; the model runs a conversion timer, captures a parallel result word when the timer expires, and returns that word MSB first on a tri-state data line. The data line is described by a value and an enable, so several instances can share one wire, each turning its enable on only while it is selected.

All three control inputs are sampled on the rising edge of the system clock `clk`, and an edge on them is seen as a change between two consecutive samples. A serial-clock falling edge is a sample of 1 followed by a sample of 0. Every output change appears right after the clock edge that sees its cause. A conversion starts only when select is high at the convert rising edge. This puts the model in select-controlled mode with its output off. After the conversion the result can be read exactly once, by pulling select low and giving 18 serial-clock falling edges.

Top module: `sar_readout_model`

## Requirements
- R1: A convert rising edge seen while select is high, and while no conversion is running, starts a conversion; from the next clock the data enable is 0.
- R2: Outside a readback, whenever select and convert are both sampled low, the data enable is 1 and the data value is 0.
- R3: A conversion lasts CONV_CYCLES clocks: `result_i` is captured on the CONV_CYCLES-th clock edge after the edge that started it, and the model then enters acquisition.
- R4: A select falling edge in acquisition starts a readback; after that clock the data enable is 1 and the data value is bit 17 (MSB) of the captured result.
- R5: After the k-th serial-clock falling edge of a readback (k from 1 to 17), the data value is bit 17-k of the captured result, with the enable held at 1.
- R6: The 18th serial-clock falling edge ends the readback and turns the enable off (convert high). The result is then consumed, and later select falling edges do not re-enable the output.
- R7: A select falling edge during a conversion is ignored: no readback starts, and none starts when the conversion ends unless select falls again.
- R8: A select rising edge during a readback aborts it at once: the enable goes to 0 and the bit counter clears. The next select falling edge restarts the readback from the MSB.
- R9: A convert rising edge seen while select is low starts no conversion, so no result becomes readable.
- R10: During and right after reset the data enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_i | input | 1 | Convert strobe; a rising edge starts a conversion |
| csel_i | input | 1 | Active-low select; its level at the convert edge chooses the mode, and its falling edge starts readback |
| sclk_i | input | 1 | Serial clock; each falling edge advances one bit |
| result_i | input | DATA_W (18) | Parallel conversion result, captured when conversion ends |
| dout_o | output | 1 | Serial data value |
| dout_oe_o | output | 1 | Serial data enable; 0 means high impedance |

## Verification
The hardest case to reach is the exact cycle on which the result word is captured, because the end of the conversion cannot be seen at any port. The stimulus places a distinct word on `result_i` for that single clock only, with other words before and after it. A timer that is one cycle early or late then reads back the wrong word. A second hard case is a select fall hidden inside a conversion. The bench drops select a few cycles after the start, holds it low past the end of the timer, and only then toggles it, to show that the early edge was not latched. A mid-word abort followed by a full restart shows that the bit counter really cleared.

// File: rtl/adcm_pkg.sv
package adcm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_ACQ  = 2'd2,
    ST_READ = 2'd3
  } adcm_state_e;
endpackage

// File: rtl/adcm_edge.sv
// Samples one control input and reports its edges between consecutive samples.
module adcm_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= RST_VAL;
    else        lvl_q <= din;
  end

  assign lvl  = lvl_q;
  assign rise = din & ~lvl_q;
  assign fall = ~din & lvl_q;
endmodule

// File: rtl/adcm_conv_timer.sv
// Down-counter that measures the conversion phase in system clocks.
module adcm_conv_timer #(
  parameter int CONV_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)             cnt_d = CNT_W'(CONV_CYCLES);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));

  AST_TMR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy); // R3
  AST_TMR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done || CONV_CYCLES == 1)); // R3
endmodule

// File: rtl/adcm_readout.sv
// Holds the captured result and the shift register/bit counter used for readback.
module adcm_readout #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              start,
  input  logic              step,
  input  logic              clear,
  output logic              res_msb,
  output logic              cur_bit,
  output logic              nxt_bit,
  output logic              last,
  output logic [$clog2(DATA_W)-1:0] bit_cnt
);
  localparam int BIT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] result_q, result_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic [BIT_W-1:0]  cnt_q, cnt_d;
  logic              last_c;

  assign last_c = (cnt_q == BIT_W'(DATA_W - 1));

  always_comb begin
    result_d = result_q;
    if (capture) result_d = cap_data;
  end

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q;
    if (start) begin
      shift_d = result_q;
      cnt_d   = '0;
    end else if (clear) begin
      cnt_d   = '0;
    end else if (step) begin
      shift_d = {shift_q[DATA_W-2:0], 1'b0};
      cnt_d   = last_c ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      shift_q  <= '0;
      cnt_q    <= '0;
    end else begin
      result_q <= result_d;
      shift_q  <= shift_d;
      cnt_q    <= cnt_d;
    end
  end

  assign res_msb = result_q[DATA_W-1];
  assign cur_bit = shift_q[DATA_W-1];
  assign nxt_bit = shift_q[DATA_W-2];
  assign last    = last_c;
  assign bit_cnt = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= BIT_W'(DATA_W - 1)); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(result_q)); // R8
endmodule

// File: rtl/sar_readout_model.sv
module sar_readout_model
  import adcm_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int CONV_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_i,
  input  logic              csel_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              dout_o,
  output logic              dout_oe_o
);
  localparam int BIT_W = $clog2(DATA_W);

  adcm_state_e state_q, state_d;

  logic conv_lvl, conv_rise, conv_fall;
  logic csel_lvl, csel_rise, csel_fall;
  logic sclk_lvl, sclk_rise, sclk_fall;
  logic tmr_start, tmr_busy, tmr_done;
  logic capture, rd_start, rd_step, rd_clear;
  logic rd_res_msb, rd_cur, rd_nxt, rd_last;
  logic [BIT_W-1:0] rd_cnt;
  logic start_ok;

  adcm_edge #(.RST_VAL(1'b0)) u_conv_edge (
    .clk(clk), .rst_n(rst_n), .din(conv_i),
    .lvl(conv_lvl), .rise(conv_rise), .fall(conv_fall));

  adcm_edge #(.RST_VAL(1'b1)) u_csel_edge (
    .clk(clk), .rst_n(rst_n), .din(csel_i),
    .lvl(csel_lvl), .rise(csel_rise), .fall(csel_fall));

  adcm_edge #(.RST_VAL(1'b0)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .din(sclk_i),
    .lvl(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall));

  adcm_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start),
    .busy(tmr_busy), .done(tmr_done));

  adcm_readout #(.DATA_W(DATA_W)) u_readout (
    .clk(clk), .rst_n(rst_n),
    .capture(capture), .cap_data(result_i),
    .start(rd_start), .step(rd_step), .clear(rd_clear),
    .res_msb(rd_res_msb), .cur_bit(rd_cur), .nxt_bit(rd_nxt),
    .last(rd_last), .bit_cnt(rd_cnt));

  // A start is accepted only with select high and no conversion running.
  assign start_ok = conv_rise && csel_i && (state_q != ST_CONV);

  always_comb begin
    state_d   = state_q;
    tmr_start = 1'b0;
    capture   = 1'b0;
    rd_start  = 1'b0;
    rd_step   = 1'b0;
    rd_clear  = 1'b0;
    unique case (state_q)
      ST_CONV: begin
        if (tmr_done) begin
          state_d = ST_ACQ;
          capture = 1'b1;
        end
      end
      ST_ACQ: begin
        if (csel_fall) begin
          state_d  = ST_READ;
          rd_start = 1'b1;
        end
      end
      ST_READ: begin
        if (csel_rise) begin
          state_d  = ST_ACQ;
          rd_clear = 1'b1;
        end else if (sclk_fall) begin
          rd_step = 1'b1;
          if (rd_last) state_d = ST_IDLE;
        end
      end
      default: ;
    endcase
    if (start_ok) begin
      state_d   = ST_CONV;
      tmr_start = 1'b1;
      rd_start  = 1'b0;
      rd_step   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign dout_oe_o = (state_q == ST_READ) | (~csel_lvl & ~conv_lvl);
  assign dout_o    = (state_q == ST_READ) & rd_cur;

  AST_START_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (state_q == ST_CONV && !dout_oe_o)); // R1
  AST_DRIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!csel_i && !conv_i && state_q != ST_READ && !(state_q == ST_ACQ && csel_fall))
      |=> (dout_oe_o && !dout_o)); // R2
  AST_CONV_TO_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV && tmr_done) |=> (state_q == ST_ACQ)); // R3
  AST_READ_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACQ && csel_fall) |=> (dout_oe_o && dout_o == $past(rd_res_msb))); // R4
  AST_SHIFT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && sclk_fall && !csel_rise && !rd_last)
      |=> (dout_oe_o && dout_o == $past(rd_nxt))); // R5
  AST_LAST_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && sclk_fall && !csel_rise && rd_last && conv_i)
      |=> !dout_oe_o); // R6
  AST_CONV_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV) |=> (state_q != ST_READ)); // R7
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && csel_rise)
      |=> (!dout_oe_o && state_q == ST_ACQ && rd_cnt == '0)); // R8
  AST_NO_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && conv_rise && !csel_i) |=> (state_q == ST_IDLE)); // R9
  AST_CONV_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV) |-> tmr_busy); // R3
endmodule

// File: tb/sar_readout_model_bench.sv
module sar_readout_model_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 18;
  localparam int NCONV      = 12;
  localparam int WATCHDOG   = 20000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          conv, csel, sclk;
  logic [DW-1:0] result;
  logic          dout, dout_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  oe;
    logic  sdo;
    string tag;
  } exp_t;
  exp_t expq[$];

  sar_readout_model #(.DATA_W(DW), .CONV_CYCLES(NCONV)) u_sar_readout_model (
    .clk(clk), .rst_n(rst_n), .conv_i(conv), .csel_i(csel), .sclk_i(sclk),
    .result_i(result), .dout_o(dout), .dout_oe_o(dout_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: pops expectations and compares them with the outputs, away from the rising edge.
  always @(negedge clk) begin
    while (expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      n_tests++;
      if (dout_oe !== e.oe || (e.oe && dout !== e.sdo)) begin
        n_fail++;
        $display("FAIL %s: got oe=%b sdo=%b, expected oe=%b sdo=%b",
                 e.tag, dout_oe, dout, e.oe, e.sdo);
      end
    end
  end

  task automatic push(input logic oe, input logic sdo, input string tag);
    exp_t e;
    e.oe = oe; e.sdo = sdo; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic set_in(input logic c, input logic s);
    @(negedge clk); conv = c; csel = s;
  endtask

  task automatic sck_fall();
    @(negedge clk); sclk = 1'b1;
    step();
    @(negedge clk); sclk = 1'b0;
    step();
  endtask

  // Gives falls first..last; checks bit 17-k after fall k, and the enable off after fall 18.
  task automatic read_bits(input logic [DW-1:0] w, input int first, input int last, input string tag);
    for (int k = first; k <= last; k++) begin
      sck_fall();
      if (k < DW) push(1'b1, w[DW-1-k], tag);
      else        push(1'b0, 1'b0, {tag, " R6 end"});
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got no finish, expected finish before %0d cycles", WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] wa, wb, wc, wd;
    wa = 18'h2A5C3; wb = 18'h0F0F0; wc = 18'h15555; wd = 18'h3C96A;
    rst_n = 1'b0; conv = 1'b0; csel = 1'b1; sclk = 1'b0; result = '0;
    step(); push(1'b0, 1'b0, "R10 in reset");
    step();
    @(negedge clk); rst_n = 1'b1;
    step(); push(1'b0, 1'b0, "R10 after reset");

    // R2: select and convert both low drive a low level
    set_in(1'b0, 1'b0); step(); push(1'b1, 1'b0, "R2 drive low");
    set_in(1'b0, 1'b1); step(); push(1'b0, 1'b0, "R2 release");

    // R9: convert rising with select low starts nothing
    set_in(1'b0, 1'b0); step();
    set_in(1'b1, 1'b0); step();
    repeat (NCONV + 3) step();
    set_in(1'b1, 1'b1); step();
    set_in(1'b1, 1'b0); step(); push(1'b0, 1'b0, "R9 no result");
    set_in(1'b0, 1'b1); step();

    // R1/R3: start a conversion, place wa on result_i only on the capture cycle
    @(negedge clk); conv = 1'b1; csel = 1'b1; result = wc;
    step(); push(1'b0, 1'b0, "R1 start hi-z");
    repeat (NCONV - 1) step();
    @(negedge clk); result = wa;
    step();
    @(negedge clk); result = wb;
    step();
    set_in(1'b1, 1'b0); step(); push(1'b1, wa[DW-1], "R4 R3 msb");
    read_bits(wa, 1, DW, "R5 R3 bits");
    set_in(1'b1, 1'b1); step();
    set_in(1'b1, 1'b0); step(); push(1'b0, 1'b0, "R6 consumed");
    set_in(1'b1, 1'b1); step();

    // R7: select falls during conversion
    set_in(1'b0, 1'b1); step();
    @(negedge clk); conv = 1'b1; result = wd;
    step();
    repeat (2) step();
    set_in(1'b1, 1'b0); step(); push(1'b0, 1'b0, "R7 fall in conv");
    repeat (NCONV + 2) step(); push(1'b0, 1'b0, "R7 after conv");

    // R8: abort mid-word, then restart from the MSB
    set_in(1'b1, 1'b1); step();
    set_in(1'b1, 1'b0); step(); push(1'b1, wd[DW-1], "R4 msb second");
    read_bits(wd, 1, 5, "R5 partial");
    set_in(1'b1, 1'b1); step(); push(1'b0, 1'b0, "R8 abort hi-z");
    set_in(1'b1, 1'b0); step(); push(1'b1, wd[DW-1], "R8 restart msb");
    read_bits(wd, 1, DW, "R8 R5 full");

    step(); step();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule